// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the control and status register bank of a host bridge. A processor-side agent reaches it over a simple word bus with one write strobe, a byte offset, write data and read data. Each access moves a full 32-bit word. Most locations store the written word and return it on a read. An interrupt-enable word cannot be written directly. It changes only through two alias locations: one ORs the written bits in, the other removes them. One configuration bit is watched for a rising write, and a rising write sends a one-cycle reset request to the system.

Reset loads a fixed set of default values. Reads are combinational from the stored words, so read data is valid in the same cycle as the offset. This lets a bus adapter put its own pipeline stage around the bank.

Top module: `hbr_ctrl_regs`

## Requirements
- R1: The word index is the byte offset shifted right by two (offset bits [7:2]). Offset bits [1:0] are ignored. There are 28 words, at byte offsets 0x00 to 0x6C.
- R2: After reset the words read 0x00000C40 at 0x00, 0x00001384 at 0x04, 0x2BFF8010 at 0x08, 0x255E0091 at 0x0C, 0x00006140 at 0x10, 0x000001FF at 0x1C and at 0x20, 0x00000008 at 0x68, and 0x10000000 at 0x6C. Every other word reads zero.
- R3: A write to any ordinary word stores the full data word. While the offset is applied, read data shows the stored value in the same cycle.
- R4: A write to the set alias at 0x30 ORs the data into the enable word at 0x38. The alias word also stores the data.
- R5: A write to the clear alias at 0x34 clears each enable bit at 0x38 whose data bit is one. The alias word also stores the data.
- R6: Writes to the enable word (0x38) and the status word (0x3C) have no effect. The status word always reads zero.
- R7: Offsets above 0x6C read zero, and writes to them change nothing.
- R8: A write to 0x04 whose data has bit 2 set, while the stored bit 2 is clear, raises reset_req for exactly one cycle, in the cycle after the write edge. The written word is still stored.
- R9: A write to 0x04 that does not take bit 2 from 0 to 1 leaves reset_req low. This covers writing bit 2 as 0, and writing bit 2 as 1 when it is already 1.
- R10: reset_req is low while rst is high and in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 8 | Byte offset for the read or write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Word at addr, combinational |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
Read data depends on addr alone and needs no clock. The bench drives the offset just after a falling edge and samples 1 ns later, in the same cycle. A write takes effect at the rising edge that samples wr_en, so a read-back issued at the next falling edge already sees the new word. The enable word follows the alias writes with the same one-edge latency. reset_req is registered once: the bench samples it at the first falling edge after the write edge, where it must be high, and again one cycle later, where it must be low.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  localparam int HBR_DW        = 32;
  localparam int HBR_IDX_GEN   = 1;   // general configuration word
  localparam int HBR_IDX_SET   = 12;  // enable set alias
  localparam int HBR_IDX_CLR   = 13;  // enable clear alias
  localparam int HBR_IDX_EN    = 14;  // enable word, read only
  localparam int HBR_IDX_STAT  = 15;  // status word, read only
  localparam int HBR_RST_BIT   = 2;   // bit of the general word that requests reset

  function automatic logic [HBR_DW-1:0] hbr_default(input int idx);
    logic [HBR_DW-1:0] v;
    case (idx)
      0:       v = 32'h0000_0C40;
      1:       v = (32'h1 << 12) | (32'h1 << 9) | (32'h1 << 8) | (32'h1 << 7) | (32'h1 << 2);
      2:       v = 32'h2BFF_8010;
      3:       v = 32'h255E_0091;
      4:       v = 32'h0000_6140;
      7, 8:    v = 32'h0000_01FF;
      26:      v = 32'h0000_0008;
      27:      v = 32'h1000_0000;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/hbr_addr_dec.sv
module hbr_addr_dec #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 28
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel,
  output logic [NUM_REGS-1:0] wr_hit
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign sel[i]    = (idx == IDX_W'(i));
    assign wr_hit[i] = wr_en && sel[i];
  end
endmodule

// File: rtl/hbr_irq_en.sv
module hbr_irq_en #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_stb,
  input  logic          clr_stb,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] en_q
);
  logic [DW-1:0] set_m;
  logic [DW-1:0] clr_m;

  assign set_m = set_stb ? data : '0;
  assign clr_m = clr_stb ? data : '0;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/hbr_rst_pulse.sv
module hbr_rst_pulse (
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic old_bit,
  input  logic new_bit,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= wr_stb && !old_bit && new_bit;
  end
endmodule

// File: rtl/hbr_ctrl_regs.sv
module hbr_ctrl_regs
  import hbr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              reset_req
);
  logic [NUM_REGS-1:0] sel;
  logic [NUM_REGS-1:0] wr_hit;
  logic [HBR_DW-1:0]   words [NUM_REGS];
  logic [HBR_DW-1:0]   en_q;

  hbr_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) dec_i (
    .wr_en  (wr_en),
    .addr   (addr),
    .sel    (sel),
    .wr_hit (wr_hit)
  );

  hbr_irq_en #(.DW(HBR_DW)) en_i (
    .clk     (clk),
    .rst     (rst),
    .set_stb (wr_hit[HBR_IDX_SET]),
    .clr_stb (wr_hit[HBR_IDX_CLR]),
    .data    (wr_data),
    .en_q    (en_q)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    if (i == HBR_IDX_EN) begin : g_en
      assign words[i] = en_q;
    end else if (i == HBR_IDX_STAT) begin : g_stat
      assign words[i] = '0;
    end else begin : g_rw
      logic [HBR_DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)            q <= hbr_default(i);
        else if (wr_hit[i]) q <= wr_data;
      end
      assign words[i] = q;
    end
  end

  hbr_rst_pulse rp_i (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_hit[HBR_IDX_GEN]),
    .old_bit (words[HBR_IDX_GEN][HBR_RST_BIT]),
    .new_bit (wr_data[HBR_RST_BIT]),
    .pulse   (reset_req)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) rd_data = words[i];
    end
  end
endmodule

// File: rtl/hbr_ctrl_regs_chk.sv
module hbr_ctrl_regs_chk
  import hbr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              reset_req,
  input logic [31:0]       en_word
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             idx_undef;
  assign idx       = addr[ADDR_W-1:2];
  assign idx_undef = (int'(idx) >= NUM_REGS);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req); // R8
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(wr_en && idx == IDX_W'(HBR_IDX_GEN) && wr_data[HBR_RST_BIT])); // R9
  AST_PULSE_QUIET_RST: assert property (@(posedge clk)
    rst |=> !reset_req); // R10
  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(HBR_IDX_SET)) |=> ((en_word & $past(wr_data)) == $past(wr_data))); // R4
  AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(HBR_IDX_CLR)) |=> ((en_word & $past(wr_data)) == '0)); // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (idx == IDX_W'(HBR_IDX_SET) || idx == IDX_W'(HBR_IDX_CLR))) |=> $stable(en_word)); // R6
  AST_STAT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (idx == IDX_W'(HBR_IDX_STAT)) |-> (rd_data == '0)); // R6
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
    idx_undef |-> (rd_data == '0)); // R7
endmodule

bind hbr_ctrl_regs hbr_ctrl_regs_chk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .addr      (addr),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .reset_req (reset_req),
  .en_word   (en_q)
);

// File: tb/hbr_ctrl_regs_tb.sv
`timescale 1ns/1ps
module hbr_ctrl_regs_tb_top;
  localparam int NREG = 28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        reset_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_w [NREG];
  logic [31:0] en_m;
  bit done = 0;

  always #4 clk = ~clk;

  hbr_ctrl_regs dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .reset_req(reset_req)
  );

  function automatic logic [31:0] dflt(input int i);
    case (i)
      0: return 32'hC40;
      1: return 32'h1384;
      2: return 32'h2BFF8010;
      3: return 32'h255E0091;
      4: return 32'h6140;
      7: return 32'h1FF;
      8: return 32'h1FF;
      26: return 32'h8;
      27: return 32'h10000000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] pat(input int i, input int s);
    return (32'h9E3779B9 * 32'(i + 1)) ^ (32'h00FF00FF << (s % 8)) ^ 32'(s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b0;
    addr  = a;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic p1, output logic p2);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1 p1 = reset_req;
    @(negedge clk);
    #1 p2 = reset_req;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int i = 0; i < NREG; i++) begin
      rd(8'(i * 4), v);
      check(req, v, exp_w[i]);
    end
  endtask

  initial begin
    logic [31:0] v;
    logic p1, p2;

    repeat (3) @(negedge clk);
    #1 check("R10", {31'b0, reset_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    #1 check("R10", {31'b0, reset_req}, 32'h0);

    // R2 defaults
    for (int i = 0; i < NREG; i++) exp_w[i] = dflt(i);
    en_m = '0;
    check_all("R2");
    // R7 reads beyond the bank
    for (int j = NREG; j < 64; j++) begin
      rd(8'(j * 4), v);
      check("R7", v, 32'h0);
    end
    // R1 low offset bits ignored
    for (int b = 0; b < 4; b++) begin
      rd(8'(2 * 4 + b), v);
      check("R1", v, 32'h2BFF8010);
    end

    // R3 plain words, low offset bits varied
    for (int i = 0; i < NREG; i++) begin
      if (i == 1 || i == 12 || i == 13 || i == 14 || i == 15) continue;
      wr(8'(i * 4 + (i % 4)), pat(i, 1), p1, p2);
      exp_w[i] = pat(i, 1);
    end
    check_all("R3");

    // R6 read-only words
    wr(8'h38, 32'hFFFFFFFF, p1, p2);
    wr(8'h3C, 32'hFFFFFFFF, p1, p2);
    rd(8'h38, v); check("R6", v, en_m);
    rd(8'h3C, v); check("R6", v, 32'h0);

    // R4 set alias sweep
    for (int k = 0; k < 8; k++) begin
      wr(8'h30, pat(k, 3) & (32'h11111111 << (k % 4)), p1, p2);
      en_m = en_m | (pat(k, 3) & (32'h11111111 << (k % 4)));
      exp_w[12] = pat(k, 3) & (32'h11111111 << (k % 4));
      exp_w[14] = en_m;
      rd(8'h38, v); check("R4", v, en_m);
      rd(8'h30, v); check("R4", v, exp_w[12]);
    end
    // R5 clear alias sweep
    for (int k = 0; k < 6; k++) begin
      wr(8'h34, pat(k, 5), p1, p2);
      en_m = en_m & ~pat(k, 5);
      exp_w[13] = pat(k, 5);
      exp_w[14] = en_m;
      rd(8'h38, v); check("R5", v, en_m);
      rd(8'h34, v); check("R5", v, exp_w[13]);
    end
    wr(8'h30, 32'hF0F0F0F0, p1, p2);
    en_m = en_m | 32'hF0F0F0F0; exp_w[12] = 32'hF0F0F0F0; exp_w[14] = en_m;
    wr(8'h38, 32'h0, p1, p2);
    rd(8'h38, v); check("R6", v, en_m);

    // R7 writes beyond the bank
    for (int j = NREG; j < 64; j++) wr(8'(j * 4), 32'hFFFFFFFF, p1, p2);
    check_all("R7");

    // R8 / R9 reset request
    wr(8'h04, 32'h0, p1, p2);
    check("R9", {30'b0, p1, p2}, 32'h0);
    wr(8'h04, 32'h4, p1, p2);
    check("R8", {30'b0, p1, p2}, 32'h2);
    rd(8'h04, v); check("R8", v, 32'h4);
    wr(8'h04, 32'h1384, p1, p2);
    check("R9", {30'b0, p1, p2}, 32'h0);
    wr(8'h04, 32'hFFFFFFFB, p1, p2);
    check("R9", {30'b0, p1, p2}, 32'h0);
    wr(8'h07, 32'hFFFFFFFF, p1, p2);
    check("R8", {30'b0, p1, p2}, 32'h2);
    rd(8'h04, v); check("R3", v, 32'hFFFFFFFF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule